// File: doc/BRIEF.md
# Start-Triggered Counting Sequencer

This block pairs a three-state controller with a small datapath. The datapath has a 4-bit counter register, a flag E and a completion flag F. The block sits idle until the start input is seen high on a clock edge. On that edge it zeroes the counter and clears F, then enters its counting state.

While counting, the counter advances by one on every edge. On the same edge, E takes the value that the counter's second bit held just before it. When the second and third counter bits are both 1 before an edge, the machine moves to a finishing state. One edge later it sets F and goes back to idle.

Every decision in a state uses register values from before the clock edge, never values written on that same edge. Counter bits are named A4 A3 A2 A1, and A1 is the least significant bit (index 0).

The controller keeps its state in a 2-bit register and decodes it into one line per state. The next-state bits come from two fixed equations on those decoded lines.

Top module: `asm_count_unit`

## Requirements
- R1: With rst high on an edge, state_out becomes 00 and a_out, e_out and f_out all become 0.
- R2: The state codes are idle = 00, count = 01 and finish = 11. In idle with start = 0, an edge leaves state_out, a_out, e_out and f_out unchanged.
- R3: In idle with start = 1, an edge sets a_out to 0, f_out to 0 and state_out to 01. e_out is unchanged.
- R4: In count, every edge sets a_out to its previous value plus one, modulo 16. f_out is unchanged.
- R5: In count, every edge loads e_out with the previous value of a_out bit 1 (A2).
- R6: From count, the next state is 11 only if a_out bits 1 and 2 (A2 and A3) were both 1 before the edge. Otherwise the state stays 01.
- R7: In finish, an edge sets f_out to 1 and state_out to 00. a_out and e_out are unchanged.
- R8: The start input has no effect in the count and finish states.
- R9: A run that begins with a start edge gives e_out the values 0,0,1,1,0,0,1 after the seven count edges. After the following finish edge, state_out is 00, a_out is 0111 and f_out is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Start request, sampled in idle |
| a_out | output | 4 | Counter register, bit 0 is A1 |
| e_out | output | 1 | Flag loaded from A2 while counting |
| f_out | output | 1 | Completion flag |
| state_out | output | 2 | Controller state code |

## Verification
On every cycle, the assertions check each single-edge step of the machine:
- idle holding or starting;
- the counter clearing, stepping or holding;
- E following the earlier A2 value;
- F being set or cleared;
- the exit condition from count.

They also check that the unused code is never present.

Only the bench scenarios can show whole-run behaviour:
- the exact E sequence across a run;
- the final counter value at completion;
- restarts with start held high;
- a reset arriving in the middle of a run.

The bench sweeps every 8-cycle start pattern against an arithmetic reference model.

// File: rtl/asm_cnt_pkg.sv
package asm_cnt_pkg;
   localparam int STATE_W   = 2;
   localparam int NUM_CODES = 1 << STATE_W;

   typedef enum logic [STATE_W-1:0] {
      ST_IDLE   = 2'b00,
      ST_COUNT  = 2'b01,
      ST_UNUSED = 2'b10,
      ST_DONE   = 2'b11
   } asm_state_e;
endpackage

// File: rtl/asm_cnt_ctrl.sv
module asm_cnt_ctrl
   import asm_cnt_pkg::*;
#(
   parameter int NEXT_STYLE = 0
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               start,
   input  logic               cond_lo,
   input  logic               cond_hi,
   output logic               t_idle,
   output logic               t_count,
   output logic               t_done,
   output logic [STATE_W-1:0] state_q
);
   logic [STATE_W-1:0]   g_q;
   logic [STATE_W-1:0]   g_d;
   logic [NUM_CODES-1:0] dec;

   if (NEXT_STYLE != 0 && NEXT_STYLE != 1) begin : g_bad_style
      $error("asm_cnt_ctrl: NEXT_STYLE must be 0 or 1");
   end

   for (genvar k = 0; k < NUM_CODES; k++) begin : g_dec
      assign dec[k] = (g_q == STATE_W'(k));
   end

   assign t_idle  = dec[int'(ST_IDLE)];
   assign t_count = dec[int'(ST_COUNT)];
   assign t_done  = dec[int'(ST_DONE)];
   assign state_q = g_q;

   if (NEXT_STYLE == 0) begin : g_eqn
      assign g_d = {t_count & cond_lo & cond_hi, (t_idle & start) | t_count};
   end else begin : g_table
      always_comb begin
         case (asm_state_e'(g_q))
            ST_IDLE:  g_d = start ? ST_COUNT : ST_IDLE;
            ST_COUNT: g_d = (cond_lo && cond_hi) ? ST_DONE : ST_COUNT;
            default:  g_d = ST_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (rst) g_q <= ST_IDLE;
      else     g_q <= g_d;
   end

   AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
      (t_idle && !start) |=> (g_q == ST_IDLE)); // R2
   AST_START_GO: assert property (@(posedge clk) disable iff (rst)
      (t_idle && start) |=> (g_q == ST_COUNT)); // R3
   AST_DONE_RETURN: assert property (@(posedge clk) disable iff (rst)
      t_done |=> (g_q == ST_IDLE)); // R7
   AST_UNUSED_RECOVER: assert property (@(posedge clk) disable iff (rst)
      dec[int'(ST_UNUSED)] |=> (g_q == ST_IDLE)); // R2
endmodule

// File: rtl/asm_cnt_counter.sv
module asm_cnt_counter #(
   parameter int WIDTH     = 4,
   parameter int CNT_STYLE = 0
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             clr,
   input  logic             inc,
   output logic [WIDTH-1:0] a_q
);
   if (WIDTH < 1) begin : g_bad_width
      $error("asm_cnt_counter: WIDTH must be at least 1");
   end

   if (CNT_STYLE == 0) begin : g_adder
      always_ff @(posedge clk) begin
         if (rst || clr) a_q <= '0;
         else if (inc)   a_q <= a_q + WIDTH'(1);
      end
   end else begin : g_toggle
      logic [WIDTH-1:0] tog;
      for (genvar i = 0; i < WIDTH; i++) begin : g_bit
         if (i == 0) begin : g_lsb
            assign tog[i] = inc;
         end else begin : g_upper
            assign tog[i] = inc & (&a_q[i-1:0]);
         end
         always_ff @(posedge clk) begin
            if (rst || clr) a_q[i] <= 1'b0;
            else if (tog[i]) a_q[i] <= ~a_q[i];
         end
      end
   end

   AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (rst)
      clr |=> (a_q == '0)); // R3
   AST_COUNT_STEP: assert property (@(posedge clk) disable iff (rst)
      (inc && !clr) |=> (a_q == $past(a_q) + WIDTH'(1))); // R4
   AST_COUNT_HOLD: assert property (@(posedge clk) disable iff (rst)
      (!inc && !clr) |=> $stable(a_q)); // R2
endmodule

// File: rtl/asm_cnt_flags.sv
module asm_cnt_flags (
   input  logic clk,
   input  logic rst,
   input  logic clr,
   input  logic load_e,
   input  logic e_src,
   input  logic set_f,
   output logic e_q,
   output logic f_q
);
   always_ff @(posedge clk) begin
      if (rst)         e_q <= 1'b0;
      else if (load_e) e_q <= e_src;
   end

   always_ff @(posedge clk) begin
      if (rst)        f_q <= 1'b0;
      else if (set_f) f_q <= 1'b1;
      else if (clr)   f_q <= 1'b0;
   end

   AST_E_FOLLOW: assert property (@(posedge clk) disable iff (rst)
      load_e |=> (e_q == $past(e_src))); // R5
   AST_E_KEEP: assert property (@(posedge clk) disable iff (rst)
      !load_e |=> $stable(e_q)); // R7
   AST_F_SET: assert property (@(posedge clk) disable iff (rst)
      set_f |=> f_q); // R7
   AST_F_CLEAR: assert property (@(posedge clk) disable iff (rst)
      (clr && !set_f) |=> !f_q); // R3
endmodule

// File: rtl/asm_count_unit.sv
module asm_count_unit
   import asm_cnt_pkg::*;
#(
   parameter int WIDTH      = 4,
   parameter int LO_BIT     = 1,
   parameter int HI_BIT     = 2,
   parameter int NEXT_STYLE = 0,
   parameter int CNT_STYLE  = 0
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               start,
   output logic [WIDTH-1:0]   a_out,
   output logic               e_out,
   output logic               f_out,
   output logic [STATE_W-1:0] state_out
);
   if (LO_BIT < 0 || LO_BIT >= WIDTH || HI_BIT < 0 || HI_BIT >= WIDTH) begin : g_bad_bits
      $error("asm_count_unit: LO_BIT and HI_BIT must lie inside the counter");
   end
   if (LO_BIT == HI_BIT) begin : g_same_bits
      $error("asm_count_unit: LO_BIT and HI_BIT must differ");
   end

   logic t_idle, t_count, t_done;
   logic clr_a, inc_a;

   asm_cnt_ctrl #(.NEXT_STYLE(NEXT_STYLE)) u_ctrl (
      .clk     (clk),
      .rst     (rst),
      .start   (start),
      .cond_lo (a_out[LO_BIT]),
      .cond_hi (a_out[HI_BIT]),
      .t_idle  (t_idle),
      .t_count (t_count),
      .t_done  (t_done),
      .state_q (state_out)
   );

   assign clr_a = t_idle & start;
   assign inc_a = t_count;

   asm_cnt_counter #(.WIDTH(WIDTH), .CNT_STYLE(CNT_STYLE)) u_cnt (
      .clk (clk),
      .rst (rst),
      .clr (clr_a),
      .inc (inc_a),
      .a_q (a_out)
   );

   asm_cnt_flags u_flags (
      .clk    (clk),
      .rst    (rst),
      .clr    (clr_a),
      .load_e (t_count),
      .e_src  (a_out[LO_BIT]),
      .set_f  (t_done),
      .e_q    (e_out),
      .f_q    (f_out)
   );

   AST_STAY_COUNT: assert property (@(posedge clk) disable iff (rst)
      (state_out == ST_COUNT && !(a_out[LO_BIT] && a_out[HI_BIT]))
      |=> (state_out == ST_COUNT)); // R6
   AST_EXIT_COUNT: assert property (@(posedge clk) disable iff (rst)
      (state_out == ST_COUNT && a_out[LO_BIT] && a_out[HI_BIT])
      |=> (state_out == ST_DONE)); // R6
   AST_NO_UNUSED: assert property (@(posedge clk) disable iff (rst)
      state_out != ST_UNUSED); // R2
   AST_F_KEEP_COUNT: assert property (@(posedge clk) disable iff (rst)
      (state_out == ST_COUNT) |=> $stable(f_out)); // R4
endmodule

// File: tb/tb_asm_count_unit.sv
module tb_asm_count_unit;
   localparam int CLK_PERIOD = 10;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       start = 1'b0;
   logic [3:0] a_out;
   logic       e_out, f_out;
   logic [1:0] state_out;

   int n_checks = 0;
   int n_fail   = 0;

   logic [1:0] m_st;
   logic [3:0] m_a;
   logic       m_e, m_f;

   asm_count_unit dut (
      .clk(clk), .rst(rst), .start(start),
      .a_out(a_out), .e_out(e_out), .f_out(f_out), .state_out(state_out)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   task automatic check(input string req, input int act, input int exp, input string what);
      n_checks++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic compare_all(input string rs, input string ra, input string re, input string rf);
      check(rs, int'(state_out), int'(m_st), "state");
      check(ra, int'(a_out), int'(m_a), "A");
      check(re, int'(e_out), int'(m_e), "E");
      check(rf, int'(f_out), int'(m_f), "F");
   endtask

   // One clock with the reference model advanced from pre-edge values.
   task automatic step(input logic s);
      logic [1:0] p;
      string rs, ra, re, rf;
      @(negedge clk);
      start = s;
      p = m_st;
      @(posedge clk);
      case (p)
         2'b00: begin
            if (s) begin m_a = 4'd0; m_f = 1'b0; m_st = 2'b01; end
            rs = s ? "R3" : "R2"; ra = rs; re = rs; rf = rs;
         end
         2'b01: begin
            m_e  = m_a[1];
            m_st = (m_a[1] && m_a[2]) ? 2'b11 : 2'b01;
            m_a  = m_a + 4'd1;
            rs = s ? "R8" : "R6"; ra = "R4"; re = "R5"; rf = "R4";
         end
         default: begin
            m_f = 1'b1; m_st = 2'b00;
            rs = s ? "R8" : "R7"; ra = "R7"; re = "R7"; rf = "R7";
         end
      endcase
      #1;
      compare_all(rs, ra, re, rf);
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst = 1'b1;
      @(posedge clk);
      #1;
      m_st = 2'b00; m_a = 4'd0; m_e = 1'b0; m_f = 1'b0;
      compare_all("R1", "R1", "R1", "R1");
      @(negedge clk);
      rst = 1'b0;
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

   initial begin
      logic [6:0] eseq;
      m_st = 2'b00; m_a = 4'd0; m_e = 1'b0; m_f = 1'b0;
      do_reset();

      // R2: idle with start low
      for (int i = 0; i < 5; i++) step(1'b0);

      // R9: one full run from a start pulse
      step(1'b1);
      for (int i = 0; i < 7; i++) begin
         step(1'b0);
         eseq[6-i] = e_out;
      end
      check("R9", int'(eseq), int'(7'b0011001), "E sequence");
      step(1'b0);
      check("R9", int'(state_out), 0, "final state");
      check("R9", int'(a_out), 7, "final A");
      check("R9", int'(f_out), 1, "final F");

      // R3: restart clears F; R8: start held high through runs
      for (int i = 0; i < 30; i++) step(1'b1);
      step(1'b0);

      // Sweep of all 8-cycle start patterns
      for (int p = 0; p < 256; p++) begin
         for (int b = 0; b < 8; b++) step(p[b]);
      end

      // R1: reset in the middle of a run
      step(1'b1);
      step(1'b0);
      step(1'b0);
      do_reset();
      for (int i = 0; i < 3; i++) step(1'b0);

      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end
endmodule